// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block sits between the rename stage and the architectural register file of an out-of-order core. It is a circular buffer. Renamed instructions take slots at the tail in program order, and each allocation hands back the slot index. Execution units report finished results against that index in any order. Results leave the buffer only from the head, so the register file always sees writes in program order.

A younger instruction may finish long before an older one. Its result is held in the buffer until every older slot has retired, so it never overtakes them into architectural state. Store and branch slots retire in order like any other slot, but they raise no register write. The allocator is back-pressured by a full indication. A flush input drops every slot in one cycle.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty: `full_o` is 0, `alloc_idx_o` is 0 and `commit_valid_o` is 0.
- R2: An allocation is taken when `alloc_valid_i` is 1, `full_o` is 0 and `flush_i` is 0. `alloc_idx_o` shows the slot it takes, and after each accepted allocation that index advances by one, wrapping from DEPTH-1 to 0.
- R3: `full_o` is 1 exactly when DEPTH slots are occupied. An allocation request while full is ignored: no slot is taken and `alloc_idx_o` does not move, even if a commit happens in the same cycle.
- R4: A completion (`cmpl_valid_i`, `cmpl_idx_i`, `cmpl_value_i`) to an occupied slot marks it finished and stores the value. A later completion to the same slot before it retires replaces the value.
- R5: `commit_valid_o` is 1 only when the oldest slot is occupied and finished. At most one slot retires per cycle, and no finished younger slot retires before an older one.
- R6: While `commit_valid_o` is 1, `commit_dest_o` and `commit_value_o` carry the oldest slot's logical destination and result. `commit_we_o` is 1 for kind codes 0 (arithmetic) and 1 (load), and 0 for kind codes 2 (store) and 3 (branch).
- R7: A completion to a slot that is not occupied, including the slot being allocated in that same cycle, has no effect.
- R8: `flush_i` has priority over all other inputs. In the flush cycle `commit_valid_o` is 0. From the next cycle the buffer is empty with `alloc_idx_o` at 0, and slots that had finished before the flush never retire.
- R9: An allocation and a retirement in the same cycle both take effect, and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the buffer |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_dest_i | input | LREG_W | Logical destination register |
| alloc_kind_i | input | 2 | Kind: 0 arithmetic, 1 load, 2 store, 3 branch |
| alloc_idx_o | output | $clog2(DEPTH) | Slot the next allocation takes |
| full_o | output | 1 | All slots occupied |
| cmpl_valid_i | input | 1 | Completion report |
| cmpl_idx_i | input | $clog2(DEPTH) | Slot being completed |
| cmpl_value_i | input | DATA_W | Result value |
| commit_valid_o | output | 1 | Oldest slot retires this cycle |
| commit_we_o | output | 1 | Register file write enable |
| commit_dest_o | output | LREG_W | Logical register to write |
| commit_value_o | output | DATA_W | Value to write |

## Verification
The bound checker watches several rules on every cycle. Occupancy never exceeds DEPTH, and a full buffer stays full with a frozen allocation index when nothing retires. The write enable never rises without a commit. A flush always leaves an empty buffer with no commit in that cycle. Allocation alone raises occupancy by one, and allocation together with retirement leaves it unchanged. Whether each retirement carries the right slot's value in program order only shows up in the bench's cycle-by-cycle comparison. The same holds for dropping stray completions and for discarding finished slots at a flush, which the bench exercises with reversed completion order, stray indices and random traffic.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_ARITH  = 2'd0,
    KIND_LOAD   = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_BRANCH = 2'd3
  } op_kind_e;

  function automatic logic kind_writes_reg(op_kind_e k);
    return (k == KIND_ARITH) || (k == KIND_LOAD);
  endfunction
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [IDX_W-1:0] wrap_inc(logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= wrap_inc(tail_q);
      if (pop_i)  head_q <= wrap_inc(head_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/rob_entries.sv
module rob_entries
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned LREG_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              alloc_en_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic [LREG_W-1:0] alloc_dest_i,
  input  op_kind_e          alloc_kind_i,
  input  logic              cmpl_en_i,
  input  logic [IDX_W-1:0]  cmpl_idx_i,
  input  logic [DATA_W-1:0] cmpl_value_i,
  input  logic              retire_en_i,
  input  logic [IDX_W-1:0]  retire_idx_i,
  output logic              valid_o [DEPTH],
  output logic              done_o  [DEPTH],
  output logic [LREG_W-1:0] dest_o  [DEPTH],
  output op_kind_e          kind_o  [DEPTH],
  output logic [DATA_W-1:0] value_o [DEPTH]
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_alloc, hit_cmpl, hit_retire;
    assign hit_alloc  = alloc_en_i  && (alloc_idx_i  == IDX_W'(g));
    assign hit_cmpl   = cmpl_en_i   && (cmpl_idx_i   == IDX_W'(g));
    assign hit_retire = retire_en_i && (retire_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        done_o[g]  <= 1'b0;
        dest_o[g]  <= '0;
        kind_o[g]  <= KIND_ARITH;
        value_o[g] <= '0;
      end else if (flush_i || hit_retire) begin
        valid_o[g] <= 1'b0;
        done_o[g]  <= 1'b0;
      end else if (hit_alloc) begin
        valid_o[g] <= 1'b1;
        done_o[g]  <= 1'b0;
        dest_o[g]  <= alloc_dest_i;
        kind_o[g]  <= alloc_kind_i;
      end else if (hit_cmpl && valid_o[g]) begin
        done_o[g]  <= 1'b1;
        value_o[g] <= cmpl_value_i;
      end
    end
  end
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned LREG_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  head_i,
  input  logic              valid_i [DEPTH],
  input  logic              done_i  [DEPTH],
  input  logic [LREG_W-1:0] dest_i  [DEPTH],
  input  op_kind_e          kind_i  [DEPTH],
  input  logic [DATA_W-1:0] value_i [DEPTH],
  output logic              commit_valid_o,
  output logic              commit_we_o,
  output logic [LREG_W-1:0] commit_dest_o,
  output logic [DATA_W-1:0] commit_value_o
);
  always_comb begin
    commit_valid_o = !flush_i && valid_i[head_i] && done_i[head_i];
    commit_we_o    = commit_valid_o && kind_writes_reg(kind_i[head_i]);
    commit_dest_o  = dest_i[head_i];
    commit_value_o = value_i[head_i];
  end
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned LREG_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     alloc_valid_i,
  input  logic [LREG_W-1:0]        alloc_dest_i,
  input  logic [1:0]               alloc_kind_i,
  output logic [$clog2(DEPTH)-1:0] alloc_idx_o,
  output logic                     full_o,
  input  logic                     cmpl_valid_i,
  input  logic [$clog2(DEPTH)-1:0] cmpl_idx_i,
  input  logic [DATA_W-1:0]        cmpl_value_i,
  output logic                     commit_valid_o,
  output logic                     commit_we_o,
  output logic [LREG_W-1:0]        commit_dest_o,
  output logic [DATA_W-1:0]        commit_value_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0]  head, tail;
  logic [CNT_W-1:0]  cnt;
  logic              push;
  logic              slot_valid [DEPTH];
  logic              slot_done  [DEPTH];
  logic [LREG_W-1:0] slot_dest  [DEPTH];
  op_kind_e          slot_kind  [DEPTH];
  logic [DATA_W-1:0] slot_value [DEPTH];

  assign push        = alloc_valid_i && !full_o && !flush_i;
  assign alloc_idx_o = tail;

  rob_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (push),
    .pop_i   (commit_valid_o),
    .head_o  (head),
    .tail_o  (tail),
    .cnt_o   (cnt),
    .full_o  (full_o)
  );

  rob_entries #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LREG_W(LREG_W), .DATA_W(DATA_W)) entries_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .alloc_en_i   (push),
    .alloc_idx_i  (tail),
    .alloc_dest_i (alloc_dest_i),
    .alloc_kind_i (op_kind_e'(alloc_kind_i)),
    .cmpl_en_i    (cmpl_valid_i),
    .cmpl_idx_i   (cmpl_idx_i),
    .cmpl_value_i (cmpl_value_i),
    .retire_en_i  (commit_valid_o),
    .retire_idx_i (head),
    .valid_o      (slot_valid),
    .done_o       (slot_done),
    .dest_o       (slot_dest),
    .kind_o       (slot_kind),
    .value_o      (slot_value)
  );

  rob_retire #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LREG_W(LREG_W), .DATA_W(DATA_W)) retire_i (
    .flush_i        (flush_i),
    .head_i         (head),
    .valid_i        (slot_valid),
    .done_i         (slot_done),
    .dest_i         (slot_dest),
    .kind_i         (slot_kind),
    .value_i        (slot_value),
    .commit_valid_o (commit_valid_o),
    .commit_we_o    (commit_we_o),
    .commit_dest_o  (commit_dest_o),
    .commit_value_o (commit_value_o)
  );
endmodule

// File: rtl/rob_top_chk.sv
module rob_top_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             alloc_valid_i,
  input logic [IDX_W-1:0] alloc_idx_o,
  input logic             full_o,
  input logic             commit_valid_o,
  input logic             commit_we_o,
  input logic [CNT_W-1:0] cnt
);
  // R3
  occupancy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH));

  // R3
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !commit_valid_o && !flush_i) |=> (full_o && $stable(alloc_idx_o)));

  // R6
  we_needs_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_we_o |-> commit_valid_o);

  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !commit_valid_o ##1 (cnt == '0 && alloc_idx_o == '0));

  // R2
  alloc_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && !full_o && !flush_i && !commit_valid_o)
      |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R9
  alloc_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && !full_o && !flush_i && commit_valid_o) |=> $stable(cnt));

  // R5
  commit_needs_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |-> cnt != '0);
endmodule

bind rob_top rob_top_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .flush_i        (flush_i),
  .alloc_valid_i  (alloc_valid_i),
  .alloc_idx_o    (alloc_idx_o),
  .full_o         (full_o),
  .commit_valid_o (commit_valid_o),
  .commit_we_o    (commit_we_o),
  .cnt            (cnt)
);

// File: tb/rob_top_tb_top.sv
module rob_top_tb_top;
  localparam int DEPTH  = 8;
  localparam int LREG_W = 5;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush;
  logic              av;
  logic [LREG_W-1:0] adest;
  logic [1:0]        akind;
  logic [IDX_W-1:0]  aidx;
  logic              full;
  logic              cv;
  logic [IDX_W-1:0]  cidx;
  logic [DATA_W-1:0] cval;
  logic              kv, kwe;
  logic [LREG_W-1:0] kdest;
  logic [DATA_W-1:0] kval;

  always #5 clk = ~clk;

  rob_top #(.DEPTH(DEPTH), .LREG_W(LREG_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .alloc_valid_i(av), .alloc_dest_i(adest), .alloc_kind_i(akind),
    .alloc_idx_o(aidx), .full_o(full),
    .cmpl_valid_i(cv), .cmpl_idx_i(cidx), .cmpl_value_i(cval),
    .commit_valid_o(kv), .commit_we_o(kwe),
    .commit_dest_o(kdest), .commit_value_o(kval)
  );

  typedef struct {
    int idx;
    int dest;
    int kind;
    bit done;
    int unsigned value;
  } ent_t;

  ent_t  mq[$];
  int    mtail = 0;
  int    checks = 0;
  int    errs = 0;
  int    cycles = 0;
  string cur_req = "R1";

  always @(posedge clk) cycles++;

  function automatic void chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
    end
  endfunction

  // one clock: drive at negedge, compare before the edge, advance model
  task automatic step(bit a_v, int a_d, int a_k, bit c_v, int c_i,
                      int unsigned c_val, bit fl);
    bit e_full, e_cv, e_we;
    av = a_v; adest = LREG_W'(a_d); akind = 2'(a_k);
    cv = c_v; cidx = IDX_W'(c_i); cval = c_val; flush = fl;
    #1;
    e_full = (mq.size() == DEPTH);
    e_cv   = !fl && mq.size() > 0 && mq[0].done;
    e_we   = e_cv && mq[0].kind < 2;
    chk("full_o", full, e_full);
    chk("alloc_idx_o", aidx, mtail);
    chk("commit_valid_o", kv, e_cv);
    chk("commit_we_o", kwe, e_we);
    if (e_cv) begin
      chk("commit_dest_o", kdest, mq[0].dest);
      chk("commit_value_o", kval, mq[0].value);
    end
    if (fl) begin
      mq.delete();
      mtail = 0;
    end else begin
      if (c_v)
        foreach (mq[i])
          if (mq[i].idx == c_i) begin
            mq[i].done = 1'b1;
            mq[i].value = c_val;
          end
      if (e_cv) void'(mq.pop_front());
      if (a_v && !e_full) begin
        mq.push_back('{idx: mtail, dest: a_d, kind: a_k, done: 1'b0, value: 0});
        mtail = (mtail + 1) % DEPTH;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    wait (cycles >= 100000);
    errs++;
    checks++;
    $display("FAIL watchdog expired act=%0d exp=0", cycles);
    summary();
  end

  initial begin
    av = 0; adest = 0; akind = 0; cv = 0; cidx = 0; cval = 0; flush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    idle(2);

    // fill, then complete in reverse order: only head-first retirement
    cur_req = "R5";
    for (int i = 0; i < DEPTH; i++) step(1, i + 1, i % 4, 0, 0, 0, 0);
    cur_req = "R3";
    step(1, 30, 0, 0, 0, 0, 0);
    chk("full after fill", full, 1);
    step(1, 31, 0, 1, 0, 32'h1234, 0);
    cur_req = "R5";
    for (int i = DEPTH - 1; i >= 1; i--) step(0, 0, 0, 1, i, 32'hA000 + i, 0);
    cur_req = "R6";
    idle(DEPTH + 2);
    chk("empty after drain", full, 0);

    // stray completion to empty slot and to slot being allocated
    cur_req = "R7";
    step(0, 0, 0, 1, 0, 32'hDEAD, 0);
    step(1, 7, 0, 1, 0, 32'hBEEF, 0);
    idle(3);
    chk("no commit after stray", kv, 0);
    step(0, 0, 0, 1, 0, 32'h55, 0);
    cur_req = "R4";
    step(0, 0, 0, 1, 0, 32'h66, 0);
    idle(2);

    // flush while entries are finished
    cur_req = "R8";
    for (int i = 0; i < 4; i++) step(1, 10 + i, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, (mtail + DEPTH - 4 + i) % DEPTH, 32'h900 + i, 0);
    step(1, 3, 0, 1, 0, 32'h77, 1);
    chk("idx after flush", aidx, 0);
    idle(3);
    chk("no commit after flush", kv, 0);

    // simultaneous allocate, complete and retire with wrap
    cur_req = "R9";
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 2, 1, 1, 0, 32'h11, 0);
    for (int i = 0; i < 20; i++) step(1, i, i % 4, 1, (mtail + DEPTH - 1) % DEPTH, 32'h200 + i, 0);
    idle(4);

    // random traffic
    cur_req = "R4";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 100;
      step($urandom % 3 != 0, $urandom % 32, $urandom % 4,
           $urandom % 2 == 0, $urandom % DEPTH, $urandom, r == 0);
    end
    cur_req = "R6";
    idle(10);
    summary();
  end
endmodule